// File: doc/BRIEF.md
# Partial-Sum Accumulate and Rectify Row Buffer

This block is the output stage of a convolution engine. For each of a set of output channels it keeps one row of 16-bit partial sums in a small on-chip memory, with one word per output column. Every clock cycle it can take one new partial sum for every channel. On the first pass over the input channels, each incoming value overwrites the stored word. On later passes the stored word is fetched, the new value is added to it with saturation, and the result is written back to the same column. All of this happens in place, in a two-stage fetch and write-back pipeline, so intermediate sums never leave the chip.

An internal column counter assigns each incoming beat to a column. The counter restarts at zero on a pass-start strobe and wraps after the last column of the row. A one-cycle done pulse marks the write-back of the last column. When every input channel has been merged, a separate readout port returns the stored sums of all channels for one column, with negative values replaced by zero.

Data words are signed fixed point with 1 sign bit, 8 integer bits and 7 fraction bits (16 bits in all).

Top module: `psum_relu_buf`

## Requirements
- R1: When a beat arrives with `accum_en` low, every channel's word at the beat's column is replaced by the incoming value, whatever it held before.
- R2: When a beat arrives with `accum_en` high, every channel's word at the beat's column becomes the stored value plus the incoming value.
- R3: The addition saturates: a sum above 32767 is stored as 32767, and a sum below -32768 is stored as -32768 (two's complement, 16 bits).
- R4: Beats may arrive on consecutive cycles or with idle gaps. Every beat is merged, with no loss and no stall.
- R5: Two beats to the same column on adjacent cycles (possible when `row_cols` is 1) accumulate correctly: the second beat sees the sum produced by the first.
- R6: A beat's column is 0 when `pass_start` is high in its cycle. Otherwise it is the previous beat's column plus one, wrapping to 0 after column `row_cols`-1. A `pass_start` with no beat clears the counter.
- R7: `pass_done` is high for exactly one cycle per beat that falls on column `row_cols`-1, two cycles after that beat is presented, and is low otherwise.
- R8: `rd_req` with `rd_addr` returns, one cycle later with `rd_valid` high, each channel's stored word at that column in its 16-bit slice of `rd_data`. Channel c occupies bits [16c+15:16c]. Negative words read as 0, and non-negative words are returned unchanged. `rd_valid` is low in any cycle that follows a cycle without `rd_req`.
- R9: After a synchronous active-low reset, `pass_done` and `rd_valid` are low, and the column counter is 0, so the first beat lands on column 0 even without `pass_start`.
- R10: Channels are independent. Each channel's slice of `in_psum` (bits [16c+15:16c]) affects only that channel's memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pass_start | input | 1 | Restart the column counter at 0 |
| in_valid | input | 1 | A beat of partial sums is present |
| accum_en | input | 1 | 0: overwrite (first pass), 1: accumulate |
| row_cols | input | AW+1 | Number of columns in the row (1..MAX_COLS) |
| in_psum | input | NUM_CH*16 | Incoming partial sums, one slice per channel |
| rd_req | input | 1 | Readout request |
| rd_addr | input | AW | Readout column |
| rd_valid | output | 1 | Readout data valid |
| rd_data | output | NUM_CH*16 | Rectified sums, one slice per channel |
| pass_done | output | 1 | Last column of the row written back |

## Verification
The bench builds the block with NUM_CH = 4 and MAX_COLS = 8. With these values a full row fits in a few cycles, so the bench can run overwrite, accumulate, wrap-around and mid-row restart passes, and read the whole row back after each one. Setting the row width to 1 makes every beat hit the same column on adjacent cycles, which exercises the forwarding path. Inputs near full scale push the sums past both saturation limits within two beats. Four channels with different data are enough to show that a slice leaking into a neighbouring channel would be caught.

// File: rtl/psum_pkg.sv
// Package: shared data format and arithmetic helpers for the partial-sum
// buffer. Words are signed 16-bit fixed point (1 sign, 8 integer, 7 fraction).
package psum_pkg;

    localparam int PSUM_W    = 16;
    localparam int INT_BITS  = 8;
    localparam int FRAC_BITS = 7;

    typedef logic signed [PSUM_W-1:0] psum_t;

    localparam psum_t PSUM_MAX = psum_t'({1'b0, {(PSUM_W-1){1'b1}}});
    localparam psum_t PSUM_MIN = psum_t'({1'b1, {(PSUM_W-1){1'b0}}});

    // Add two words, clamping to the representable range instead of wrapping.
    function automatic psum_t sat_add(input psum_t a, input psum_t b);
        logic signed [PSUM_W:0] wide;
        wide = {a[PSUM_W-1], a} + {b[PSUM_W-1], b};
        if (wide[PSUM_W] != wide[PSUM_W-1])
            return wide[PSUM_W] ? PSUM_MIN : PSUM_MAX;
        return psum_t'(wide[PSUM_W-1:0]);
    endfunction

    // Single-point rectifier: negative words become zero.
    function automatic psum_t relu(input psum_t a);
        return a[PSUM_W-1] ? '0 : a;
    endfunction

endpackage

// File: rtl/psum_col_ctr.sv
// Module: psum_col_ctr
// Assigns each incoming beat to an output column and flags the end of a row.
// Assumes row_cols lies in 1..2**AW. The beat column is combinational
// (0 when pass_start is high, otherwise the stored counter). The done pulse
// is aligned with the write-back stage of the lanes, one cycle after the
// fetch stage.
module psum_col_ctr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pass_start,
    input  logic          in_valid,
    input  logic [AW:0]   row_cols,
    output logic [AW-1:0] beat_col,
    output logic [AW-1:0] cnt_q,
    output logic          pass_done
);

    logic [AW-1:0] cur_col;
    logic          is_last;
    logic          last_s1;

    // Column of the beat in this cycle, and whether it closes the row.
    always_comb begin
        cur_col = pass_start ? '0 : cnt_q;
        is_last = ({1'b0, cur_col} == (row_cols - 1'b1));
    end

    assign beat_col = cur_col;

    // Advance the counter on each beat, wrap at row end, clear on pass start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (in_valid)
            cnt_q <= is_last ? '0 : cur_col + 1'b1;
        else if (pass_start)
            cnt_q <= '0;
    end

    // Delay the row-end flag through the fetch and write-back stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_s1   <= 1'b0;
            pass_done <= 1'b0;
        end else begin
            last_s1   <= in_valid && is_last;
            pass_done <= last_s1;
        end
    end

endmodule

// File: rtl/psum_lane.sv
// Module: psum_lane
// One output channel. It holds a row of MAX_COLS partial sums and merges
// beats through a two-stage pipeline. Stage 1 fetches the stored word and
// registers the column, data and mode. Stage 2 adds (or passes through) and
// writes back. When a write-back and the next fetch hit the same column, the
// sum just written is forwarded. A separate read port returns the rectified
// word one cycle after a request. Assumes readout does not overlap writes to
// the same column.
module psum_lane
    import psum_pkg::*;
#(
    parameter int MAX_COLS = 128,
    parameter int AW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_vld,
    input  logic          beat_acc,
    input  logic [AW-1:0] beat_col,
    input  psum_t         beat_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output psum_t         rd_word
);

    psum_t         mem [MAX_COLS];

    logic          s1_vld;
    logic          s1_acc;
    logic [AW-1:0] s1_col;
    psum_t         s1_data;
    psum_t         s1_old;

    logic          wb_vld;
    logic [AW-1:0] wb_col;
    psum_t         wb_sum;

    psum_t         base;
    psum_t         new_sum;

    // Stage 1 control: capture the beat's column, mode and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_acc  <= 1'b0;
            s1_col  <= '0;
            s1_data <= '0;
        end else begin
            s1_vld  <= beat_vld;
            s1_acc  <= beat_acc;
            s1_col  <= beat_col;
            s1_data <= beat_data;
        end
    end

    // Stage 1 fetch: synchronous read of the stored word for the beat's column.
    always_ff @(posedge clk) begin
        s1_old <= mem[beat_col];
    end

    // Stage 2 merge: forward the last write-back on a column match, then add.
    always_comb begin
        base    = (wb_vld && (wb_col == s1_col)) ? wb_sum : s1_old;
        new_sum = s1_acc ? sat_add(base, s1_data) : s1_data;
    end

    // Stage 2 write-back into the row memory.
    always_ff @(posedge clk) begin
        if (s1_vld)
            mem[s1_col] <= new_sum;
    end

    // Forwarding register: remembers the last column written and its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld <= 1'b0;
            wb_col <= '0;
            wb_sum <= '0;
        end else begin
            wb_vld <= s1_vld;
            wb_col <= s1_col;
            wb_sum <= new_sum;
        end
    end

    // Readout port: rectify the stored word on its way out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (rd_req)
            rd_word <= relu(mem[rd_addr]);
    end

endmodule

// File: rtl/psum_relu_buf.sv
// Module: psum_relu_buf (top)
// Partial-sum accumulate and rectify buffer. One psum_lane per output
// channel shares a single column counter. Beats carry one 16-bit partial sum
// per channel, and readout returns all channels for one column. Assumes
// row_cols lies in 1..MAX_COLS, and that readout is issued only after the
// last write-back of the row.
module psum_relu_buf
    import psum_pkg::*;
#(
    parameter  int NUM_CH   = 16,
    parameter  int MAX_COLS = 128,
    localparam int AW       = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1,
    localparam int BUS_W    = NUM_CH * PSUM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass_start,
    input  logic             in_valid,
    input  logic             accum_en,
    input  logic [AW:0]      row_cols,
    input  logic [BUS_W-1:0] in_psum,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_valid,
    output logic [BUS_W-1:0] rd_data,
    output logic             pass_done
);

    logic [AW-1:0] beat_col;
    logic [AW-1:0] col_cnt;

    psum_col_ctr #(.AW(AW)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pass_start (pass_start),
        .in_valid   (in_valid),
        .row_cols   (row_cols),
        .beat_col   (beat_col),
        .cnt_q      (col_cnt),
        .pass_done  (pass_done)
    );

    // One lane per output channel, each on its own slice of the buses.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        psum_t lane_out;

        psum_lane #(.MAX_COLS(MAX_COLS), .AW(AW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .beat_vld  (in_valid),
            .beat_acc  (accum_en),
            .beat_col  (beat_col),
            .beat_data (psum_t'(in_psum[ch*PSUM_W +: PSUM_W])),
            .rd_req    (rd_req),
            .rd_addr   (rd_addr),
            .rd_word   (lane_out)
        );

        assign rd_data[ch*PSUM_W +: PSUM_W] = lane_out;
    end

    // Readout valid follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= rd_req;
    end

endmodule

// File: rtl/psum_relu_buf_chk.sv
// Module: psum_relu_buf_chk
// Property checker bound to psum_relu_buf. It watches readout timing, the
// sign of rectified data, counter restart and done-pulse origin.
module psum_relu_buf_chk #(
    parameter int NUM_CH = 16,
    parameter int AW     = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pass_start,
    input logic                 in_valid,
    input logic                 rd_req,
    input logic                 rd_valid,
    input logic [NUM_CH*16-1:0] rd_data,
    input logic                 pass_done,
    input logic [AW-1:0]        col_cnt
);

    logic any_neg;

    // Collect the sign bits of every readout slice.
    always_comb begin
        any_neg = 1'b0;
        for (int c = 0; c < NUM_CH; c++)
            any_neg = any_neg | rd_data[c*16 + 15];
    end

    AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);                                   // R8
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);                                 // R8
    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !any_neg);                                 // R8
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_start && !in_valid) |=> (col_cnt == '0));         // R6
    AST_DONE_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> $past(in_valid, 2));                      // R7

endmodule

bind psum_relu_buf psum_relu_buf_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_start (pass_start),
    .in_valid   (in_valid),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .pass_done  (pass_done),
    .col_cnt    (col_cnt)
);

// File: tb/psum_relu_buf_bench.sv
`timescale 1ns/1ps
// Bench: behavioural row model (integer arrays) compared on every clock.
module psum_relu_buf_bench;

    localparam int NCH   = 4;
    localparam int COLS  = 8;
    localparam int AW    = 3;
    localparam int MAXCY = 200000;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                pass_start;
    logic                in_valid;
    logic                accum_en;
    logic [AW:0]         row_cols;
    logic [NCH*16-1:0]   in_psum;
    logic                rd_req;
    logic [AW-1:0]       rd_addr;
    logic                rd_valid;
    logic [NCH*16-1:0]   rd_data;
    logic                pass_done;

    psum_relu_buf #(.NUM_CH(NCH), .MAX_COLS(COLS)) u_psum_relu_buf (
        .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .in_valid(in_valid),
        .accum_en(accum_en), .row_cols(row_cols), .in_psum(in_psum),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .pass_done(pass_done)
    );

    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    int ref_row [NCH][COLS];
    int m_cnt = 0;
    int rc    = COLS;
    bit done_pipe [2];
    bit rv_exp = 0;
    int rd_exp [NCH];
    string rd_tag = "R8";

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int gen(input int ch, input int col, input int k);
        if (k == -1) return 30000 - ch;
        if (k == -2) return -30000 + ch;
        return ((col * 37 + ch * 101 + k * 53) % 4001) - 2000;
    endfunction

    // One clock: check outputs due now, then apply this cycle's inputs and
    // advance the model.
    task automatic cycle(input bit st, input bit v, input bit acc, input int k,
                         input bit rr, input int ra);
        int cur;
        bit last;
        @(negedge clk);
        chk("R7", "pass_done", int'(pass_done), int'(done_pipe[1]));
        chk("R8", "rd_valid", int'(rd_valid), int'(rv_exp));
        if (rv_exp)
            for (int c = 0; c < NCH; c++)
                chk(rd_tag, $sformatf("rd_data ch%0d", c),
                    int'($signed(rd_data[c*16 +: 16])), rd_exp[c]);
        cur  = st ? 0 : m_cnt;
        last = v && (cur == rc - 1);
        pass_start = st;
        in_valid   = v;
        accum_en   = acc;
        row_cols   = rc[AW:0];
        rd_req     = rr;
        rd_addr    = ra[AW-1:0];
        for (int c = 0; c < NCH; c++) begin
            int d;
            d = v ? gen(c, cur, k) : 0;
            in_psum[c*16 +: 16] = d[15:0];
            if (v) ref_row[c][cur] = acc ? sat(ref_row[c][cur] + d) : d;
        end
        if (v) m_cnt = last ? 0 : cur + 1;
        else if (st) m_cnt = 0;
        done_pipe[1] = done_pipe[0];
        done_pipe[0] = last;
        rv_exp = rr;
        if (rr)
            for (int c = 0; c < NCH; c++)
                rd_exp[c] = (ref_row[c][ra] < 0) ? 0 : ref_row[c][ra];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0);
    endtask

    task automatic read_row(input string tag);
        rd_tag = tag;
        idle(2);
        for (int a = 0; a < rc; a++) cycle(0, 0, 0, 0, 1, a);
        idle(1);
        rd_tag = "R8";
    endtask

    initial begin
        rst_n = 0; pass_start = 0; in_valid = 0; accum_en = 0;
        row_cols = COLS[AW:0]; in_psum = '0; rd_req = 0; rd_addr = '0;
        done_pipe[0] = 0; done_pipe[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: outputs low after reset
        chk("R9", "pass_done after reset", int'(pass_done), 0);
        chk("R9", "rd_valid after reset", int'(rd_valid), 0);

        // R9/R1/R10: first pass without pass_start starts at column 0
        for (int i = 0; i < COLS; i++) cycle(0, 1, 0, 1, 0, 0);
        read_row("R1_R9_R10");

        // R2/R4: accumulate with back-to-back beats and idle gaps
        cycle(1, 1, 1, 2, 0, 0);
        for (int i = 1; i < COLS; i++) begin
            cycle(0, 1, 1, 3 + i, 0, 0);
            if (i % 3 == 0) idle(1);
        end
        read_row("R2_R4");

        // R3: push past the positive limit, then past the negative limit
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < COLS; i++) cycle(i == 0, 1, p > 0, -1, 0, 0);
        read_row("R3_pos");
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < COLS; i++) cycle(i == 0, 1, 1, -2, 0, 0);
        read_row("R3_neg");

        // R1: an overwrite pass replaces saturated contents
        for (int i = 0; i < COLS; i++) cycle(i == 0, 1, 0, 7, 0, 0);
        read_row("R1");

        // R6: restart mid-row, and a bare pass_start clears the counter
        for (int i = 0; i < 3; i++) cycle(0, 1, 1, 9, 0, 0);
        cycle(1, 1, 1, 11, 0, 0);
        cycle(0, 1, 1, 12, 0, 0);
        cycle(1, 0, 0, 0, 0, 0);
        cycle(0, 1, 1, 13, 0, 0);
        read_row("R6");

        // R5: single-column row, accumulate on adjacent cycles
        rc = 1;
        cycle(1, 1, 0, 20, 0, 0);
        for (int i = 0; i < 6; i++) cycle(0, 1, 1, 21 + i, 0, 0);
        read_row("R5");
        rc = COLS;

        idle(3);
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * MAXCY);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule